// File: doc/BRIEF.md
# Fixed-Rate Periodic Interrupt Timer

This block raises a periodic interrupt request from a 32.768 kHz timebase at one of eight rates. The rates are spaced by powers of two, from 64 Hz down to 0.5 Hz. A free-running 16-bit prescaler advances once per cycle in which the timebase enable is high. Each rate corresponds to one prescaler bit, and an interrupt event occurs when the selected bit goes from 0 to 1.

Software controls the block through one write-only byte on a synchronous write port. Only the upper nibble of that byte belongs to this block: an enable bit and a 3-bit rate code. The lower nibble holds fields owned by other units, and this block ignores it.

The interrupt line is shared with a second, programmable timer. The block has one event input for that timer. It drives a single pending output and a source flag that records which timer caused the most recent event. Neither the pending flag nor the source flag has a data stream, so all pins are plain level or strobe signals with no handshake.

Top module: `fixed_rate_irq_timer`

## Requirements
- R1: After reset, `irq_pend` and `src_prog` are 0, the control field is 0 (interrupt disabled), and the prescaler is 0.
- R2: While control bit 7 is 0, no fixed-rate event is raised, whatever bits 6:4 hold.
- R3: With bit 7 = 1 and code 000 (bits 6:4), the first event after reset occurs on the 256th timebase tick. Later events follow every 512 ticks (64 Hz).
- R4: With bit 7 = 1, code c selects prescaler bit 8+c. The first event after reset occurs on tick 2^(8+c): 001 = 32 Hz, 011 = 8 Hz, 111 = 0.5 Hz (tick 32768).
- R5: Bits 3:0 of the written byte have no effect on rate or enable.
- R6: Writing a new rate code does not reset the prescaler. The next event follows the next rising edge of the newly selected prescaler bit, counted from reset.
- R7: `irq_pend` stays set until an `irq_clr` strobe. If a new event arrives in the same cycle as `irq_clr`, `irq_pend` stays 1.
- R8: The prescaler advances only in cycles where `tick_32k` is 1. While it is 0, no event occurs.
- R9: `src_prog` becomes 1 after a `prog_evt` and 0 after a fixed-rate event. When both arrive in the same cycle, it becomes 1. `irq_clr` leaves it unchanged. A `prog_evt` also sets `irq_pend`.
- R10: The control field changes only in a cycle with `ctrl_wr` high. Data presented without `ctrl_wr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable marking each 32.768 kHz timebase period |
| ctrl_wr | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 8 | Control byte: bit 7 enable, bits 6:4 rate code, bits 3:0 ignored |
| prog_evt | input | 1 | Event strobe from the programmable timer sharing the line |
| irq_clr | input | 1 | Clears the pending flag |
| irq_pend | output | 1 | Shared interrupt pending |
| src_prog | output | 1 | 1 = last event from the programmable timer, 0 = from this fixed timer |

## Verification
The assertions check several properties on every cycle:
- the prescaler holds still without a tick;
- at most one prescaler bit rises at once;
- no fixed event occurs while the field is disabled;
- the field is stable without a write;
- the pending flag holds and wins against a simultaneous clear;
- the source flag follows the cause of each event.

Only the bench scenarios can show the absolute timing. That covers the exact tick on which each rate first fires, the 512-tick period, a rate change that keeps the prescaler phase, and the fact that lower-nibble bits leave the rate unchanged.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int FRT_RATES  = 8;
  localparam int FRT_CODE_W = $clog2(FRT_RATES);

  typedef struct packed {
    logic                  en;
    logic [FRT_CODE_W-1:0] code;
  } frt_ctrl_t;
endpackage

// File: rtl/frt_ctrl_reg.sv
module frt_ctrl_reg
  import frt_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int EN_BIT   = 7,
  parameter int CODE_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output frt_ctrl_t         ctrl
);
  localparam int CODE_MSB = CODE_LSB + FRT_CODE_W - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr) begin
      ctrl.en   <= wdata[EN_BIT];
      ctrl.code <= wdata[CODE_MSB:CODE_LSB];
    end
  end

  // R10: field moves only on a write strobe
  a_r10_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctrl));
endmodule

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
  parameter int CNT_W  = 16,
  parameter int TAP_LO = 8,
  parameter int N_TAPS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [N_TAPS-1:0] tap_rise
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // A tap bit rises on the tick where it is 0 and every lower bit is 1.
  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    localparam int B = TAP_LO + k;
    if (B == 0) begin : g_lsb
      assign tap_rise[k] = tick & ~cnt[0];
    end else begin : g_upper
      assign tap_rise[k] = tick & ~cnt[B] & (&cnt[B-1:0]);
    end
  end

  // R8: prescaler frozen without a timebase tick
  a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R4: taps are exclusive, one rate edge at a time
  a_r4_single_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tap_rise));
endmodule

// File: rtl/frt_irq_latch.sv
module frt_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fixed_evt,
  input  logic prog_evt,
  input  logic clr,
  output logic pend,
  output logic src_prog
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      src_prog <= 1'b0;
    end else begin
      if (fixed_evt || prog_evt) pend <= 1'b1;
      else if (clr)              pend <= 1'b0;
      if (prog_evt)              src_prog <= 1'b1;
      else if (fixed_evt)        src_prog <= 1'b0;
    end
  end

  // R7: pending holds until cleared
  a_r7_hold_pend: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !clr |=> pend);
  // R7: event beats a simultaneous clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_evt || prog_evt) |=> pend);
  // R9: source flag tracks the cause
  a_r9_src_prog: assert property (@(posedge clk) disable iff (!rst_n)
    prog_evt |=> src_prog);
  a_r9_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_evt && !prog_evt |=> !src_prog);
  a_r9_clr_keeps_src: assert property (@(posedge clk) disable iff (!rst_n)
    !fixed_evt && !prog_evt |=> $stable(src_prog));
endmodule

// File: rtl/fixed_rate_irq_timer.sv
module fixed_rate_irq_timer
  import frt_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int EN_BIT   = 7,
  parameter int CODE_LSB = 4,
  parameter int CNT_W    = 16,
  parameter int TAP_LO   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] ctrl_wdata,
  input  logic              prog_evt,
  input  logic              irq_clr,
  output logic              irq_pend,
  output logic              src_prog
);
  frt_ctrl_t             ctrl;
  logic [FRT_RATES-1:0]  tap_rise;
  logic                  fixed_evt;

  frt_ctrl_reg #(.BYTE_W(BYTE_W), .EN_BIT(EN_BIT), .CODE_LSB(CODE_LSB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata), .ctrl(ctrl)
  );

  frt_prescaler #(.CNT_W(CNT_W), .TAP_LO(TAP_LO), .N_TAPS(FRT_RATES)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .tap_rise(tap_rise)
  );

  assign fixed_evt = ctrl.en & tap_rise[ctrl.code];

  frt_irq_latch u_latch (
    .clk(clk), .rst_n(rst_n), .fixed_evt(fixed_evt), .prog_evt(prog_evt),
    .clr(irq_clr), .pend(irq_pend), .src_prog(src_prog)
  );

  // R2: a disabled field never yields a fixed event
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> !fixed_evt);
  // R8: no fixed event without a tick
  a_r8_event_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_evt |-> tick_32k);
endmodule

// File: tb/tb_fixed_rate_irq_timer.sv
module tb_fixed_rate_irq_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_32k = 1'b0;
  logic ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic prog_evt = 1'b0;
  logic irq_clr = 1'b0;
  logic irq_pend, src_prog;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fixed_rate_irq_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .prog_evt(prog_evt), .irq_clr(irq_clr),
    .irq_pend(irq_pend), .src_prog(src_prog)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_32k = 0; ctrl_wr = 0; prog_evt = 0; irq_clr = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_ctrl(logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0; ctrl_wdata = 8'h00;
  endtask

  // n ticks; returns at a negedge with all n ticks visible on the outputs
  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_32k = 1'b1;
    end
    @(negedge clk); tick_32k = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 pend", irq_pend, 1'b0);
    check("R1 src", src_prog, 1'b0);
    run_ticks(256);
    check("R1 disabled after reset", irq_pend, 1'b0);
  endtask

  task automatic t_disabled();
    do_reset();
    write_ctrl(8'h70);
    run_ticks(40000);
    check("R2 en=0 code=111", irq_pend, 1'b0);
    do_reset();
    write_ctrl(8'h0F);
    run_ticks(1024);
    check("R2 en=0 code=000", irq_pend, 1'b0);
  endtask

  task automatic t_no_strobe();
    do_reset();
    @(negedge clk); ctrl_wdata = 8'h80;
    run_ticks(600);
    ctrl_wdata = 8'h00;
    check("R10 data without strobe", irq_pend, 1'b0);
  endtask

  task automatic t_rate(int code);
    int first;
    first = 1 << (8 + code);
    do_reset();
    write_ctrl(8'h80 | 8'(code << 4));
    run_ticks(first - 1);
    check($sformatf("R4 code %0d before tap edge", code), irq_pend, 1'b0);
    run_ticks(1);
    check($sformatf("R4 code %0d at tap edge", code), irq_pend, 1'b1);
    check($sformatf("R9 code %0d source fixed", code), src_prog, 1'b0);
  endtask

  task automatic t_64hz_period();
    do_reset();
    write_ctrl(8'h80);
    run_ticks(255);
    check("R3 tick 255", irq_pend, 1'b0);
    run_ticks(1);
    check("R3 tick 256", irq_pend, 1'b1);
    pulse_clr();
    check("R7 clear", irq_pend, 1'b0);
    run_ticks(511);
    check("R3 tick 767", irq_pend, 1'b0);
    run_ticks(1);
    check("R3 tick 768 period 512", irq_pend, 1'b1);
  endtask

  task automatic t_low_bits();
    do_reset();
    write_ctrl(8'h8F);
    run_ticks(255);
    check("R5 low nibble tick 255", irq_pend, 1'b0);
    run_ticks(1);
    check("R5 low nibble tick 256", irq_pend, 1'b1);
  endtask

  task automatic t_rate_change();
    do_reset();
    write_ctrl(8'h80);
    run_ticks(300);
    check("R6 first 64 Hz event", irq_pend, 1'b1);
    pulse_clr();
    write_ctrl(8'h90);
    run_ticks(211);
    check("R6 tick 511 after change", irq_pend, 1'b0);
    run_ticks(1);
    check("R6 tick 512 new tap edge", irq_pend, 1'b1);
  endtask

  task automatic t_clear_race();
    do_reset();
    write_ctrl(8'h80);
    run_ticks(256);
    run_ticks(100);
    check("R7 held without clear", irq_pend, 1'b1);
    pulse_clr();
    check("R7 cleared", irq_pend, 1'b0);
    run_ticks(411);
    check("R7 tick 767", irq_pend, 1'b0);
    @(negedge clk); tick_32k = 1'b1; irq_clr = 1'b1;
    @(negedge clk); tick_32k = 1'b0; irq_clr = 1'b0;
    check("R7 event beats clear", irq_pend, 1'b1);
  endtask

  task automatic t_tick_gate();
    do_reset();
    write_ctrl(8'h80);
    run_ticks(255);
    repeat (100) @(negedge clk);
    check("R8 no tick no event", irq_pend, 1'b0);
    run_ticks(1);
    check("R8 resumes on tick 256", irq_pend, 1'b1);
  endtask

  task automatic t_source();
    do_reset();
    @(negedge clk); prog_evt = 1'b1;
    @(negedge clk); prog_evt = 1'b0;
    check("R9 prog sets pend", irq_pend, 1'b1);
    check("R9 prog source", src_prog, 1'b1);
    pulse_clr();
    check("R9 clear keeps source", src_prog, 1'b1);
    write_ctrl(8'h80);
    run_ticks(256);
    check("R9 fixed source", src_prog, 1'b0);
    do_reset();
    write_ctrl(8'h80);
    run_ticks(255);
    @(negedge clk); tick_32k = 1'b1; prog_evt = 1'b1;
    @(negedge clk); tick_32k = 1'b0; prog_evt = 1'b0;
    check("R9 simultaneous prefers prog", src_prog, 1'b1);
    check("R9 simultaneous pend", irq_pend, 1'b1);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_no_strobe();
    t_64hz_period();
    t_rate(1);
    t_rate(3);
    t_rate(7);
    t_low_bits();
    t_rate_change();
    t_clear_race();
    t_tick_gate();
    t_source();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule